// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM that keeps its data path busy on every clock cycle. Reads and writes can alternate cycle by cycle without an idle cycle between them. A write takes its data two enabled clock edges after its command. A read puts its data on the output two enabled edges after its command. Because both directions have the same latency, the data bus never needs a turnaround slot.

Each rising edge samples a clock enable, a chip select, an advance strobe, a write enable and per-byte write enables. When advance is low, a new operation starts, or the chip is deselected. When advance is high, the operation in progress continues at the address on the address input, which a separate burst generator supplies. A small internal array takes byte-masked writes. A read that targets a word whose write data is arriving on the same edge returns the merged, up-to-date word. Read data leaves through an output register. An output enable gates the data valid flag asynchronously.

Top module: `zt_sram`

## Requirements
- R1: A read command registered at enabled edge k drives `dq_oe` high and its word on `dq_out` after enabled edge k+2, provided `oe_n` is low. Each read beat is shown for exactly one enabled cycle.
- R2: For a write command registered at enabled edge k, the data is taken from `wdata` at enabled edge k+2. Byte lane i is bits [8i+7:8i] and is written only when `be_n[i]` was 0 with that command.
- R3: Read and write commands may alternate on consecutive enabled edges in either order, with no idle cycle. Every read returns the word that results from all earlier-issued writes. A write command never raises `dq_oe`.
- R4: A write command with `be_n` all ones is a no-op and leaves every word unchanged.
- R5: An edge with `cke_n` high ignores all synchronous inputs and changes no state: `dq_out` and `dq_oe` hold, and a pending write still takes its data at its second enabled edge.
- R6: `adv` high with `cke_n` low continues the current burst at the address on `addr`. A read burst continues as reads and a write burst continues as writes, with `we_n` ignored.
- R7: `csel_n` high with `adv` low is a deselect. Continue cycles (`adv` high) after a deselect neither read nor write the array.
- R8: A read with `oe_n` high runs as a dummy read and `dq_oe` stays low. `oe_n` acts on `dq_oe` without waiting for a clock edge.
- R9: A read issued one edge after a write to the same address returns the new bytes in the written lanes and the old bytes elsewhere.
- R10: After synchronous reset no operation is pending, `dq_oe` is low and the device is deselected, so continue cycles right after reset do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| csel_n | input | 1 | Chip select, active low, sampled when adv is low |
| adv | input | 1 | Low starts a new operation, high continues the burst |
| we_n | input | 1 | Low selects write, high selects read, sampled when adv is low |
| be_n | input | NB | Active-low byte write enables, one per lane |
| addr | input | AW | Word address: start address or generator's next address |
| wdata | input | NB*LW | Write data, taken two enabled edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | NB*LW | Registered read data |
| dq_oe | output | 1 | High when dq_out carries a read beat and oe_n is low |

## Verification
On the same enabled edge the array can commit the data of a write issued two edges earlier while a read issued one edge earlier fetches its word. When both target the same address, the read must see the bytes just committed. The bench provokes this by issuing every masked write directly followed by a read of the same word, across all sixteen byte-mask patterns and several addresses, and it also issues read-then-write pairs. The result is judged against a reference memory in the bench. That memory is updated in command order, at the edge each write's data arrives, before the reads that fall due on that edge. Clock-enable stalls are placed between a write command and its data so that the commit is deferred as well.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Operation carried by a command slot.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Operation selected when a new command is started.
    function automatic op_e start_op(input logic csel_n, input logic we_n);
        if (csel_n)
            return OP_NONE;
        else if (we_n)
            return OP_READ;
        else
            return OP_WRITE;
    endfunction

    // A byte lane is replaced when its mask bit is set.
    function automatic logic [7:0] lane_pick(input logic take_new,
                                             input logic [7:0] old_b,
                                             input logic [7:0] new_b);
        return take_new ? new_b : old_b;
    endfunction

endpackage

// File: rtl/zt_sram_decode.sv
module zt_sram_decode
    import zt_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke_n,
    input  logic          csel_n,
    input  logic          adv,
    input  logic          we_n,
    input  logic [NB-1:0] be_n,
    input  logic [AW-1:0] addr,
    output op_e           cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [NB-1:0] cmd_mask
);

    op_e mode_q;
    op_e fresh_op;

    always_comb begin
        fresh_op = start_op(csel_n, we_n);
        cmd_op   = adv ? mode_q : fresh_op;
        cmd_addr = addr;
        cmd_mask = ~be_n;
    end

    // Burst mode: remembered at every start so that continue cycles repeat it.
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= OP_NONE;
        else if (!cke_n && !adv)
            mode_q <= fresh_op;
    end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
    import zt_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke_n,
    input  op_e           cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [NB-1:0] cmd_mask,
    output logic          s1_rd,
    output logic [AW-1:0] s1_addr,
    output logic          s2_rd,
    output logic          s2_wr,
    output logic [AW-1:0] s2_addr,
    output logic [NB-1:0] s2_mask
);

    typedef struct packed {
        logic          vld;
        op_e           op;
        logic [AW-1:0] addr;
        logic [NB-1:0] mask;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{vld: 1'b0, op: OP_NONE, addr: '0, mask: '0};

    slot_t s1_q, s2_q, s1_d;

    always_comb begin
        s1_d.vld  = (cmd_op != OP_NONE);
        s1_d.op   = cmd_op;
        s1_d.addr = cmd_addr;
        s1_d.mask = cmd_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= SLOT_EMPTY;
            s2_q <= SLOT_EMPTY;
        end else if (!cke_n) begin
            s1_q <= s1_d;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        s1_rd   = s1_q.vld && (s1_q.op == OP_READ);
        s1_addr = s1_q.addr;
        s2_rd   = s2_q.vld && (s2_q.op == OP_READ);
        s2_wr   = s2_q.vld && (s2_q.op == OP_WRITE);
        s2_addr = s2_q.addr;
        s2_mask = s2_q.mask;
    end

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int AW = 4,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_mask,
    input  logic [NB*LW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*LW-1:0] rd_data
);

    localparam int NW = 1 << AW;

    for (genvar l = 0; l < NB; l++) begin : g_lane
        logic [LW-1:0] lane_mem [NW];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                lane_mem[wr_addr] <= wr_data[l*LW +: LW];
        end

        assign rd_data[l*LW +: LW] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/zt_sram_rdpath.sv
module zt_sram_rdpath #(
    parameter int AW = 4,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             s1_rd,
    input  logic [AW-1:0]    s1_addr,
    input  logic             s2_rd,
    input  logic             s2_wr,
    input  logic [AW-1:0]    s2_addr,
    input  logic [NB-1:0]    s2_mask,
    input  logic [NB*LW-1:0] wdata,
    input  logic [NB*LW-1:0] arr_data,
    input  logic             oe_n,
    output logic [NB*LW-1:0] dq_out,
    output logic             dq_oe
);

    localparam int DW = NB * LW;

    logic          hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] stage_q;
    logic [DW-1:0] out_q;
    logic          out_vld_q;

    // Write data landing on this edge overrides the stale array lanes.
    assign hit = s2_wr && (s2_addr == s1_addr);

    for (genvar l = 0; l < NB; l++) begin : g_fwd
        assign merged[l*LW +: LW] = (hit && s2_mask[l]) ? wdata[l*LW +: LW]
                                                        : arr_data[l*LW +: LW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else if (!cke_n) begin
            if (s1_rd)
                stage_q <= merged;
            out_vld_q <= s2_rd;
            if (s2_rd)
                out_q <= stage_q;
        end
    end

    assign dq_out = out_q;
    assign dq_oe  = out_vld_q & ~oe_n;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             csel_n,
    input  logic             adv,
    input  logic             we_n,
    input  logic [NB-1:0]    be_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*LW-1:0] wdata,
    input  logic             oe_n,
    output logic [NB*LW-1:0] dq_out,
    output logic             dq_oe
);

    localparam int DW = NB * LW;

    op_e           cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [NB-1:0] cmd_mask;
    logic          s1_rd, s2_rd, s2_wr;
    logic [AW-1:0] s1_addr, s2_addr;
    logic [NB-1:0] s2_mask;
    logic [DW-1:0] arr_data;
    logic          commit;

    zt_sram_decode #(.AW(AW), .NB(NB)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .csel_n   (csel_n),
        .adv      (adv),
        .we_n     (we_n),
        .be_n     (be_n),
        .addr     (addr),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_mask (cmd_mask)
    );

    zt_sram_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_mask (cmd_mask),
        .s1_rd    (s1_rd),
        .s1_addr  (s1_addr),
        .s2_rd    (s2_rd),
        .s2_wr    (s2_wr),
        .s2_addr  (s2_addr),
        .s2_mask  (s2_mask)
    );

    assign commit = s2_wr && !cke_n;

    zt_sram_array #(.AW(AW), .NB(NB), .LW(LW)) u_arr (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (s2_addr),
        .wr_mask (s2_mask),
        .wr_data (wdata),
        .rd_addr (s1_addr),
        .rd_data (arr_data)
    );

    zt_sram_rdpath #(.AW(AW), .NB(NB), .LW(LW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .s1_rd    (s1_rd),
        .s1_addr  (s1_addr),
        .s2_rd    (s2_rd),
        .s2_wr    (s2_wr),
        .s2_addr  (s2_addr),
        .s2_mask  (s2_mask),
        .wdata    (wdata),
        .arr_data (arr_data),
        .oe_n     (oe_n),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cke_n,
    input logic          csel_n,
    input logic          adv,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);

    logic rd_start, wr_start, desel;
    assign rd_start = !cke_n && !adv && !csel_n && we_n;
    assign wr_start = !cke_n && !adv && !csel_n && !we_n;
    assign desel    = !cke_n && !adv && csel_n;

    p_rd_latency_r1: assert property (@(posedge clk) disable iff (rst)
        rd_start ##1 !cke_n ##1 !cke_n ##1 !oe_n |-> dq_oe);

    p_wr_no_out_r3: assert property (@(posedge clk) disable iff (rst)
        wr_start ##1 !cke_n ##1 !cke_n |=> !dq_oe);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> $stable(dq_out));

    p_desel_cont_r7: assert property (@(posedge clk) disable iff (rst)
        desel ##1 (!cke_n && adv) ##1 !cke_n ##1 !cke_n |=> !dq_oe);

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !dq_oe);

endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cke_n  (cke_n),
    .csel_n (csel_n),
    .adv    (adv),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int LW = 8;
    localparam int DW = NB * LW;
    localparam int NW = 1 << AW;
    localparam int HMAX = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke_n = 1'b0, csel_n = 1'b1, adv = 1'b0, we_n = 1'b1, oe_n = 1'b0;
    logic [NB-1:0] be_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    zt_sram #(.AW(AW), .NB(NB), .LW(LW)) dut (
        .clk(clk), .rst(rst), .cke_n(cke_n), .csel_n(csel_n), .adv(adv),
        .we_n(we_n), .be_n(be_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Reference state: command history per enabled edge, memory in command order.
    int            hk   [HMAX];   // 0 none, 1 read, 2 write
    int            ha   [HMAX];
    logic [NB-1:0] hm   [HMAX];
    logic [DW-1:0] hwd  [HMAX];
    logic [DW-1:0] hexp [HMAX];
    string         htag [HMAX];
    logic [DW-1:0] ref_mem [NW];
    int            ec = 0;
    int            mode = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [DW-1:0] prev_out;
    logic          prev_oe;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // One clock: drive at the falling edge, model the rising edge, check at the next falling edge.
    task automatic step(input logic c_cke_n, input logic c_csel_n, input logic c_adv,
                        input logic c_we_n, input logic [NB-1:0] c_be_n, input int c_addr,
                        input logic [DW-1:0] c_wd, input logic c_oe_n, input string tag);
        int k;
        int kind;
        cke_n  = c_cke_n;
        csel_n = c_csel_n;
        adv    = c_adv;
        we_n   = c_we_n;
        be_n   = c_be_n;
        addr   = c_addr[AW-1:0];
        oe_n   = c_oe_n;
        if (!c_cke_n && ec >= 2 && hk[ec-2] == 2)
            wdata = hwd[ec-2];
        else
            wdata = 32'hBAD0_0000 | DW'(ec) | 32'h0000_F0F0;
        k = ec;
        if (!c_cke_n) begin
            if (!c_adv) begin
                kind = c_csel_n ? 0 : (c_we_n ? 1 : 2);
                mode = kind;
            end else begin
                kind = mode;
            end
            hk[k] = kind; ha[k] = c_addr; hm[k] = ~c_be_n; hwd[k] = c_wd; htag[k] = tag;
        end
        @(posedge clk);
        if (!c_cke_n) begin
            if (k >= 2 && hk[k-2] == 2)
                for (int l = 0; l < NB; l++)
                    if (hm[k-2][l]) ref_mem[ha[k-2]][l*LW +: LW] = hwd[k-2][l*LW +: LW];
            if (k >= 1 && hk[k-1] == 1)
                hexp[k-1] = ref_mem[ha[k-1]];
            ec++;
        end
        @(negedge clk);
        if (c_cke_n) begin
            chk(dq_out == prev_out, "R5", "stall data hold", dq_out, prev_out);
            chk(dq_oe == prev_oe, "R5", "stall valid hold", DW'(dq_oe), DW'(prev_oe));
        end else if (k >= 2 && hk[k-2] == 1) begin
            chk(dq_oe == !c_oe_n, htag[k-2], "read valid", DW'(dq_oe), DW'(!c_oe_n));
            if (!c_oe_n)
                chk(dq_out == hexp[k-2], htag[k-2], "read data", dq_out, hexp[k-2]);
        end else begin
            chk(dq_oe == 1'b0, tag, "no read beat", DW'(dq_oe), '0);
        end
        prev_out = dq_out;
        prev_oe  = dq_oe;
    endtask

    task automatic wr(input int a, input logic [NB-1:0] b, input logic [DW-1:0] d,
                      input logic cont, input string tag);
        step(1'b0, 1'b0, cont, 1'b0, b, a, d, 1'b0, tag);
    endtask

    task automatic rd(input int a, input logic cont, input logic o, input string tag);
        step(1'b0, 1'b0, cont, 1'b1, '0, a, '0, o, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b1, '1, 0, '0, 1'b0, tag);
    endtask

    // Stall with command-like garbage on every synchronous input (write to word 9).
    task automatic stall();
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, 9, '0, oe_n, "R5");
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(32'h9E37_79B9 * (i + 1)) ^ DW'(32'h0102_0304 * i);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            summary();
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < HMAX; i++) hk[i] = 0;
        // R10: reset state
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R10", "valid in reset", DW'(dq_oe), '0);
        end
        rst = 1'b0;
        prev_out = dq_out;
        prev_oe  = dq_oe;
        // R10: continue cycles right after reset must not start a read
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, '0, i, '0, 1'b0, "R10");

        // R2/R6: fill every word with one write burst
        for (int a = 0; a < NW; a++) wr(a, '0, pat(a), a != 0, "R6");
        idle("R2"); idle("R2");
        // R1/R6: read burst back
        for (int a = 0; a < NW; a++) rd(a, a != 0, 1'b0, "R1");
        idle("R1"); idle("R1");

        // R9/R4: masked write followed at once by a read of the same word
        for (int i = 0; i < 32; i++) begin
            int a;
            a = (i * 5) % NW;
            wr(a, 4'(i), pat(i + 40), 1'b0, (i % 16 == 15) ? "R4" : "R9");
            rd(a, 1'b0, 1'b0, (i % 16 == 15) ? "R4" : "R9");
        end
        // R3: read then write of the same word, back to back
        for (int i = 0; i < 8; i++) begin
            rd(i * 2, 1'b0, 1'b0, "R3");
            wr(i * 2, 4'(i * 3), pat(i + 90), 1'b0, "R3");
        end
        idle("R3"); idle("R3");

        // R5: stalls inside a write burst and between command and data
        wr(3, '0, pat(200), 1'b0, "R5");
        stall();
        wr(4, 4'b0101, pat(201), 1'b1, "R5");
        stall(); stall();
        wr(5, '0, pat(202), 1'b1, "R5");
        idle("R5");
        stall();
        idle("R5"); idle("R5");
        rd(3, 1'b0, 1'b0, "R5");
        rd(4, 1'b1, 1'b0, "R5");
        stall();
        rd(5, 1'b1, 1'b0, "R5");
        stall(); stall();
        rd(9, 1'b1, 1'b0, "R5");
        idle("R5"); stall(); idle("R5");

        // R7: deselect, then continue cycles with write-like inputs
        idle("R7");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, '0, 2 + i, pat(300 + i), 1'b0, "R7");
        rd(11, 1'b0, 1'b0, "R7");
        idle("R7");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, '0, i, '0, 1'b0, "R7");
        rd(2, 1'b0, 1'b0, "R7"); rd(3, 1'b1, 1'b0, "R7"); rd(4, 1'b1, 1'b0, "R7");
        idle("R7"); idle("R7");

        // R8: dummy read with output disabled, then asynchronous gating
        rd(7, 1'b0, 1'b1, "R8");
        idle("R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, '1, 0, '0, 1'b1, "R8");
        rd(6, 1'b0, 1'b0, "R8");
        idle("R8"); idle("R8");
        chk(dq_oe == 1'b1, "R8", "valid before gating", DW'(dq_oe), DW'(1));
        #2 oe_n = 1'b1;
        #1 chk(dq_oe == 1'b0, "R8", "async disable", DW'(dq_oe), '0);
        oe_n = 1'b0;
        #1 chk(dq_oe == 1'b1, "R8", "async enable", DW'(dq_oe), DW'(1));
        prev_oe = dq_oe;
        idle("R8");

        // R1: final read-back of every word
        for (int a = 0; a < NW; a++) rd(a, 1'b0, 1'b0, "R1");
        idle("R1"); idle("R1"); idle("R1");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule